// File: doc/BRIEF.md
# Serial Byte Command and Register Decoder

This block turns a stream of bytes received from a host over a serial link into controller commands and 16-bit register accesses for a touch-screen conversion controller. Every byte accepted while the link is selected yields one response byte. The first byte of a transaction is decoded by its top bit. With bit 7 set, the byte is a complete one-byte command. It can reprogram the conversion function, the precision and the sense enable, or it can wipe the block back to its reset state. Any other non-zero first byte is a header that opens a three-byte register transfer.

The block holds the writable registers: four threshold registers and three configuration registers, each stored through its own field mask. It drives their contents out as plain outputs. For reads it issues a strobe with the register address to the neighbouring status and data logic and takes the value that logic returns. It then shifts the captured word out over the two bytes that follow the header. Bit-level shifting and the analog conversion lie outside this block.

Top module: `spi_byte_decoder`

## Requirements
- R1: A first byte with bit 7 set is a command that ends in that byte. If bit 1 is set, all registers and command state return to their reset values and soft_reset_o pulses. Otherwise bits 6:3 load conv_func_o, bit 2 loads conv_prec_o (1 = 12-bit), bit 0 set clears sense_en_o and bit 0 clear sets it, and cmd_strobe_o pulses.
- R2: A first byte of 0x00 gets a 0x00 response and causes no strobe and no register change. The next byte is decoded as a first byte again.
- R3: A non-zero first byte with bit 7 clear is a header. Bits 6:3 are the register address, bit 1 is presented on pd_flag_o, and bit 0 set selects a read. A read header pulses rd_strobe_o and holds the address on rd_addr_o.
- R4: The read value is captured one clock after the header. The response to the header is 0x00, the response to the second byte is value bits 15:8, and the response to the third byte is value bits 7:0. All responses of a write are 0x00.
- R5: On a write, the second byte gives bits 15:8 and the third byte gives bits 7:0. Nothing changes until the third byte has arrived.
- R6: The threshold registers are at addresses 0x8 (aux high, reset 0x0FFF), 0x9 (aux low, reset 0x0000), 0xA (temperature high, reset 0x0FFF) and 0xB (temperature low, reset 0x0000). Each stores and reads back all 16 bits.
- R7: Writing 0xC sets host_mode_o from bit 15, sense_en_o from the inverse of bit 14, conv_prec_o from bit 13 and timing_o from bits 12:0.
- R8: Reading 0xC returns pen_down_i in bit 15, the inverse of busy_i in bit 14, conv_prec_o in bit 13 and timing_o in bits 12:0.
- R9: A write to 0xC with bit 14 set while busy_i is high pulses abort_o.
- R10: Writing 0xD stores only the bits under mask 0x0F07, and reading 0xD returns the stored value.
- R11: Writing 0xE stores bits 15:14 into pin_func_o and bits 13:0 into filter_o. Reading 0xE returns them in those positions.
- R12: Writes to addresses 0x0–0x7 and 0xF change nothing. Reads of those addresses return rd_data_i.
- R13: While sel_i is low, received bytes are ignored and the transaction returns to the first-byte state, discarding any partial transfer.
- R14: tx_valid_o pulses for one clock after each byte accepted with sel_i high, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Link selected; low aborts any transfer |
| rx_valid_i | input | 1 | One-clock pulse: rx_byte_i holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Response byte ready |
| tx_byte_o | output | 8 | Response byte for the last accepted byte |
| rd_strobe_o | output | 1 | Read request pulse to status/data logic |
| rd_addr_o | output | 4 | Address of the current register transfer |
| rd_data_i | input | 16 | Value from status/data logic for rd_addr_o |
| pen_down_i | input | 1 | Pen-down flag for configuration 0 readback |
| busy_i | input | 1 | Conversion in progress |
| pd_flag_o | output | 1 | Power-down control bit of the last header |
| cmd_strobe_o | output | 1 | Pulse after a non-reset command |
| soft_reset_o | output | 1 | Pulse after a reset command |
| conv_func_o | output | 4 | Next conversion function |
| conv_prec_o | output | 1 | Next precision, 1 = 12-bit |
| sense_en_o | output | 1 | Touch sensing enabled |
| abort_o | output | 1 | Pulse: running conversion must stop |
| host_mode_o | output | 1 | Host-controlled conversion mode |
| timing_o | output | 13 | Timing field of configuration 0 |
| cfg1_o | output | 16 | Masked configuration 1 |
| pin_func_o | output | 2 | Interrupt pin function |
| filter_o | output | 14 | Filter setting |
| aux_hi_o | output | 16 | Aux high threshold |
| aux_lo_o | output | 16 | Aux low threshold |
| temp_hi_o | output | 16 | Temperature high threshold |
| temp_lo_o | output | 16 | Temperature low threshold |

## Verification
The hardest case to reach is a write torn apart by a deselect. The stimulus sends a header and a high byte, drops sel_i while a byte is offered, and then reselects the link. It then sends a command byte, which has an effect only if the decoder has fallen back to the first-byte state. The threshold must still hold its previous value. The bench also places a zero byte in front of a command to show that the zero byte leaves the first-byte state in place. It toggles busy_i and pen_down_i between header and capture to check which clock the configuration 0 readback samples.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_W    = 2 * BYTE_W;
  localparam int ADDR_W   = 4;
  localparam int FUNC_W   = 4;
  localparam int TIMING_W = REG_W - 3;
  localparam int PINF_W   = 2;
  localparam int FILTER_W = REG_W - PINF_W;
  localparam int NUM_THR  = 4;
  localparam int THR_BASE = 8;

  localparam logic [ADDR_W-1:0] A_CFG0 = 4'hC;
  localparam logic [ADDR_W-1:0] A_CFG1 = 4'hD;
  localparam logic [ADDR_W-1:0] A_CFG2 = 4'hE;

  typedef enum logic [1:0] {
    XS_HDR = 2'd0,
    XS_HI  = 2'd1,
    XS_LO  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_i,
  input  logic                rx_valid_i,
  input  logic [BYTE_W-1:0]   rx_byte_i,
  input  logic [REG_W-1:0]    shadow_val_i,
  output xfer_state_e         state_o,
  output logic                tx_valid_o,
  output logic [BYTE_W-1:0]   tx_byte_o,
  output logic                cmd_go_o,
  output logic [FUNC_W-1:0]   cmd_func_o,
  output logic                cmd_prec_o,
  output logic                cmd_en_o,
  output logic                soft_rst_o,
  output logic                wr_go_o,
  output logic [REG_W-1:0]    wr_data_o,
  output logic                rd_go_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                pd_flag_o
);
  xfer_state_e       state_q;
  logic              is_rd_q;
  logic [BYTE_W-1:0] hi_q;
  logic [REG_W-1:0]  shadow_q;

  assign state_o = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= XS_HDR;
      is_rd_q    <= 1'b0;
      hi_q       <= '0;
      shadow_q   <= '0;
      tx_valid_o <= 1'b0;
      tx_byte_o  <= '0;
      cmd_go_o   <= 1'b0;
      cmd_func_o <= '0;
      cmd_prec_o <= 1'b0;
      cmd_en_o   <= 1'b0;
      soft_rst_o <= 1'b0;
      wr_go_o    <= 1'b0;
      wr_data_o  <= '0;
      rd_go_o    <= 1'b0;
      addr_o     <= '0;
      pd_flag_o  <= 1'b0;
    end else begin
      tx_valid_o <= 1'b0;
      cmd_go_o   <= 1'b0;
      soft_rst_o <= 1'b0;
      wr_go_o    <= 1'b0;
      rd_go_o    <= 1'b0;
      if (rd_go_o) shadow_q <= shadow_val_i;
      if (!sel_i) begin
        state_q <= XS_HDR;
      end else if (rx_valid_i) begin
        tx_valid_o <= 1'b1;
        tx_byte_o  <= '0;
        unique case (state_q)
          XS_HDR: begin
            if (rx_byte_i[7]) begin
              if (rx_byte_i[1]) begin
                soft_rst_o <= 1'b1;
              end else begin
                cmd_go_o   <= 1'b1;
                cmd_func_o <= rx_byte_i[6:3];
                cmd_prec_o <= rx_byte_i[2];
                cmd_en_o   <= ~rx_byte_i[0];
              end
            end else if (rx_byte_i != '0) begin
              addr_o    <= rx_byte_i[6:3];
              pd_flag_o <= rx_byte_i[1];
              is_rd_q   <= rx_byte_i[0];
              rd_go_o   <= rx_byte_i[0];
              hi_q      <= '0;
              state_q   <= XS_HI;
            end
          end
          XS_HI: begin
            if (is_rd_q) tx_byte_o <= shadow_q[REG_W-1:BYTE_W];
            else         hi_q      <= rx_byte_i;
            state_q <= XS_LO;
          end
          XS_LO: begin
            if (is_rd_q) begin
              tx_byte_o <= shadow_q[BYTE_W-1:0];
            end else begin
              wr_go_o   <= 1'b1;
              wr_data_o <= {hi_q, rx_byte_i};
            end
            state_q <= XS_HDR;
          end
          default: state_q <= XS_HDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_dec_pkg::*;
#(
  parameter logic [REG_W-1:0] THR_HI_RST = 16'h0FFF,
  parameter logic [REG_W-1:0] THR_LO_RST = 16'h0000,
  parameter logic [REG_W-1:0] CFG1_MASK  = 16'h0F07
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           soft_rst_i,
  input  logic                           cmd_go_i,
  input  logic [FUNC_W-1:0]              cmd_func_i,
  input  logic                           cmd_prec_i,
  input  logic                           cmd_en_i,
  input  logic                           wr_go_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [REG_W-1:0]               wr_data_i,
  input  logic                           busy_i,
  output logic [NUM_THR-1:0][REG_W-1:0]  thr_o,
  output logic [FUNC_W-1:0]              func_o,
  output logic                           prec_o,
  output logic                           en_o,
  output logic                           host_o,
  output logic [TIMING_W-1:0]            timing_o,
  output logic [REG_W-1:0]               cfg1_o,
  output logic [PINF_W-1:0]              pinf_o,
  output logic [FILTER_W-1:0]            filter_o,
  output logic                           abort_o
);
  logic clr;
  logic wr_cfg0, wr_cfg1, wr_cfg2;
  logic [REG_W-1:0] thr_q [NUM_THR];

  assign clr     = rst | soft_rst_i;
  assign wr_cfg0 = wr_go_i && (wr_addr_i == A_CFG0);
  assign wr_cfg1 = wr_go_i && (wr_addr_i == A_CFG1);
  assign wr_cfg2 = wr_go_i && (wr_addr_i == A_CFG2);

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    localparam logic [REG_W-1:0] RST_V = (g % 2 == 0) ? THR_HI_RST : THR_LO_RST;
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(THR_BASE + g);
    always_ff @(posedge clk) begin
      if (clr)                              thr_q[g] <= RST_V;
      else if (wr_go_i && wr_addr_i == MY_A) thr_q[g] <= wr_data_i;
    end
    assign thr_o[g] = thr_q[g];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      func_o   <= '0;
      prec_o   <= 1'b0;
      en_o     <= 1'b0;
      host_o   <= 1'b0;
      timing_o <= '0;
      cfg1_o   <= '0;
      pinf_o   <= '0;
      filter_o <= '0;
      abort_o  <= 1'b0;
    end else begin
      abort_o <= wr_cfg0 && wr_data_i[14] && busy_i;
      if (cmd_go_i) begin
        func_o <= cmd_func_i;
        prec_o <= cmd_prec_i;
        en_o   <= cmd_en_i;
      end
      if (wr_cfg0) begin
        host_o   <= wr_data_i[15];
        en_o     <= ~wr_data_i[14];
        prec_o   <= wr_data_i[13];
        timing_o <= wr_data_i[TIMING_W-1:0];
      end
      if (wr_cfg1) cfg1_o <= wr_data_i & CFG1_MASK;
      if (wr_cfg2) begin
        pinf_o   <= wr_data_i[REG_W-1:FILTER_W];
        filter_o <= wr_data_i[FILTER_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spi_rd_mux.sv
module spi_rd_mux
  import spi_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_THR-1:0][REG_W-1:0]  thr_i,
  input  logic                           pen_down_i,
  input  logic                           busy_i,
  input  logic                           prec_i,
  input  logic [TIMING_W-1:0]            timing_i,
  input  logic [REG_W-1:0]               cfg1_i,
  input  logic [PINF_W-1:0]              pinf_i,
  input  logic [FILTER_W-1:0]            filter_i,
  input  logic [REG_W-1:0]               ext_i,
  output logic [REG_W-1:0]               val_o
);
  always_comb begin
    val_o = ext_i;
    if (addr_i >= ADDR_W'(THR_BASE) && addr_i < ADDR_W'(THR_BASE + NUM_THR))
      val_o = thr_i[addr_i[$clog2(NUM_THR)-1:0]];
    else if (addr_i == A_CFG0)
      val_o = {pen_down_i, ~busy_i, prec_i, timing_i};
    else if (addr_i == A_CFG1)
      val_o = cfg1_i;
    else if (addr_i == A_CFG2)
      val_o = {pinf_i, filter_i};
  end
endmodule

// File: rtl/spi_byte_decoder.sv
module spi_byte_decoder
  import spi_dec_pkg::*;
#(
  parameter logic [15:0] THR_HI_RST = 16'h0FFF,
  parameter logic [15:0] THR_LO_RST = 16'h0000,
  parameter logic [15:0] CFG1_MASK  = 16'h0F07
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_i,
  input  logic         rx_valid_i,
  input  logic [7:0]   rx_byte_i,
  output logic         tx_valid_o,
  output logic [7:0]   tx_byte_o,
  output logic         rd_strobe_o,
  output logic [3:0]   rd_addr_o,
  input  logic [15:0]  rd_data_i,
  input  logic         pen_down_i,
  input  logic         busy_i,
  output logic         pd_flag_o,
  output logic         cmd_strobe_o,
  output logic         soft_reset_o,
  output logic [3:0]   conv_func_o,
  output logic         conv_prec_o,
  output logic         sense_en_o,
  output logic         abort_o,
  output logic         host_mode_o,
  output logic [12:0]  timing_o,
  output logic [15:0]  cfg1_o,
  output logic [1:0]   pin_func_o,
  output logic [13:0]  filter_o,
  output logic [15:0]  aux_hi_o,
  output logic [15:0]  aux_lo_o,
  output logic [15:0]  temp_hi_o,
  output logic [15:0]  temp_lo_o
);
  xfer_state_e                  state;
  logic                         cmd_go, soft_rst, wr_go, rd_go, cmd_prec, cmd_en;
  logic [FUNC_W-1:0]            cmd_func;
  logic [REG_W-1:0]             wr_data, rd_val;
  logic [ADDR_W-1:0]            addr;
  logic [NUM_THR-1:0][REG_W-1:0] thr;

  spi_xfer_seq u_seq (
    .clk(clk), .rst(rst), .sel_i(sel_i), .rx_valid_i(rx_valid_i),
    .rx_byte_i(rx_byte_i), .shadow_val_i(rd_val), .state_o(state),
    .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .cmd_go_o(cmd_go),
    .cmd_func_o(cmd_func), .cmd_prec_o(cmd_prec), .cmd_en_o(cmd_en),
    .soft_rst_o(soft_rst), .wr_go_o(wr_go), .wr_data_o(wr_data),
    .rd_go_o(rd_go), .addr_o(addr), .pd_flag_o(pd_flag_o)
  );

  spi_cfg_regs #(
    .THR_HI_RST(THR_HI_RST), .THR_LO_RST(THR_LO_RST), .CFG1_MASK(CFG1_MASK)
  ) u_regs (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .cmd_go_i(cmd_go),
    .cmd_func_i(cmd_func), .cmd_prec_i(cmd_prec), .cmd_en_i(cmd_en),
    .wr_go_i(wr_go), .wr_addr_i(addr), .wr_data_i(wr_data), .busy_i(busy_i),
    .thr_o(thr), .func_o(conv_func_o), .prec_o(conv_prec_o), .en_o(sense_en_o),
    .host_o(host_mode_o), .timing_o(timing_o), .cfg1_o(cfg1_o),
    .pinf_o(pin_func_o), .filter_o(filter_o), .abort_o(abort_o)
  );

  spi_rd_mux u_mux (
    .addr_i(addr), .thr_i(thr), .pen_down_i(pen_down_i), .busy_i(busy_i),
    .prec_i(conv_prec_o), .timing_i(timing_o), .cfg1_i(cfg1_o),
    .pinf_i(pin_func_o), .filter_i(filter_o), .ext_i(rd_data_i), .val_o(rd_val)
  );

  assign rd_strobe_o  = rd_go;
  assign rd_addr_o    = addr;
  assign cmd_strobe_o = cmd_go;
  assign soft_reset_o = soft_rst;
  assign aux_hi_o     = thr[0];
  assign aux_lo_o     = thr[1];
  assign temp_hi_o    = thr[2];
  assign temp_lo_o    = thr[3];
endmodule

// File: rtl/spi_byte_decoder_chk.sv
module spi_byte_decoder_chk
  import spi_dec_pkg::*;
#(
  parameter logic [15:0] THR_HI_RST = 16'h0FFF,
  parameter logic [15:0] CFG1_MASK  = 16'h0F07
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_i,
  input logic         rx_valid_i,
  input logic [7:0]   rx_byte_i,
  input xfer_state_e  state,
  input logic         tx_valid_o,
  input logic         rd_strobe_o,
  input logic         wr_go,
  input logic [3:0]   addr,
  input logic [15:0]  wr_data,
  input logic [15:0]  cfg1_o,
  input logic         abort_o,
  input logic         sense_en_o,
  input logic         soft_reset_o,
  input logic [15:0]  aux_hi_o
);
  assert_cmd_one_byte_R1: assert property (@(posedge clk) disable iff (rst)
    (sel_i && rx_valid_i && rx_byte_i[7] && state == XS_HDR) |=> state == XS_HDR);

  assert_zero_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_i && rx_valid_i && rx_byte_i == 8'h00 && state == XS_HDR)
      |=> (state == XS_HDR && !rd_strobe_o));

  assert_rd_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    rd_strobe_o |-> $past(sel_i && rx_valid_i && !rx_byte_i[7] && rx_byte_i[0]
                          && state == XS_HDR));

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (rst)
    soft_reset_o |=> aux_hi_o == THR_HI_RST);

  assert_abort_disables_R9: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> !sense_en_o);

  assert_cfg1_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_go && addr == A_CFG1) |=> cfg1_o == ($past(wr_data) & CFG1_MASK));

  assert_sel_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> state == XS_HDR);

  assert_tx_valid_R14: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> $past(sel_i && rx_valid_i));
endmodule

bind spi_byte_decoder spi_byte_decoder_chk #(
  .THR_HI_RST(THR_HI_RST), .CFG1_MASK(CFG1_MASK)
) u_chk (
  .clk(clk), .rst(rst), .sel_i(sel_i), .rx_valid_i(rx_valid_i),
  .rx_byte_i(rx_byte_i), .state(state), .tx_valid_o(tx_valid_o),
  .rd_strobe_o(rd_strobe_o), .wr_go(wr_go), .addr(addr), .wr_data(wr_data),
  .cfg1_o(cfg1_o), .abort_o(abort_o), .sense_en_o(sense_en_o),
  .soft_reset_o(soft_reset_o), .aux_hi_o(aux_hi_o)
);

// File: tb/tb_spi_byte_decoder.sv
module tb_spi_byte_decoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, sel_i, rx_valid_i, pen_down_i, busy_i;
  logic [7:0] rx_byte_i, tx_byte_o;
  logic tx_valid_o, rd_strobe_o, pd_flag_o, cmd_strobe_o, soft_reset_o;
  logic [3:0] rd_addr_o, conv_func_o;
  logic [15:0] rd_data_i, cfg1_o, aux_hi_o, aux_lo_o, temp_hi_o, temp_lo_o;
  logic conv_prec_o, sense_en_o, abort_o, host_mode_o;
  logic [12:0] timing_o;
  logic [1:0] pin_func_o;
  logic [13:0] filter_o;

  assign rd_data_i = {4'hA, rd_addr_o, 8'h3C};

  spi_byte_decoder dut (.*);

  int checks = 0, fails = 0;
  int rd_cnt = 0, abort_cnt = 0, srst_cnt = 0, cmd_cnt = 0, txv_cnt = 0, sent = 0;
  logic [7:0] exp_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_strobe_o)  rd_cnt++;
      if (abort_o)      abort_cnt++;
      if (soft_reset_o) srst_cnt++;
      if (cmd_strobe_o) cmd_cnt++;
      if (tx_valid_o) begin
        txv_cnt++;
        if (exp_q.size() == 0) check("R14 unexpected response", 32'(tx_byte_o), 32'hFFFF);
        else check("R4 response byte", 32'(tx_byte_o), 32'(exp_q.pop_front()));
      end
    end
  end

  task automatic send(logic [7:0] b, logic [7:0] resp);
    @(negedge clk);
    rx_valid_i = 1'b1; rx_byte_i = b;
    exp_q.push_back(resp); sent++;
    @(negedge clk);
    rx_valid_i = 1'b0; rx_byte_i = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    send({1'b0, a, 3'b000}, 8'h00);
    send(d[15:8], 8'h00);
    send(d[7:0], 8'h00);
  endtask

  task automatic rd(logic [3:0] a, logic [15:0] expv);
    send({1'b0, a, 3'b001}, 8'h00);
    send(8'h00, expv[15:8]);
    send(8'h00, expv[7:0]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c0;
    rst = 1'b1; sel_i = 1'b1; rx_valid_i = 1'b0; rx_byte_i = 8'h00;
    pen_down_i = 1'b0; busy_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R6 reset state
    check("R6 aux hi reset", 32'(aux_hi_o), 32'h0FFF);
    check("R6 aux lo reset", 32'(aux_lo_o), 32'h0000);
    check("R6 temp hi reset", 32'(temp_hi_o), 32'h0FFF);
    check("R6 temp lo reset", 32'(temp_lo_o), 32'h0000);
    check("R1 enable reset", 32'(sense_en_o), 32'h0);
    check("R4 tx reset", 32'(tx_byte_o), 32'h0);

    // R1 command: func 5, 12-bit, sense on
    send(8'hAC, 8'h00);
    check("R1 func", 32'(conv_func_o), 32'h5);
    check("R1 prec", 32'(conv_prec_o), 32'h1);
    check("R1 enable", 32'(sense_en_o), 32'h1);
    check("R1 cmd strobe", 32'(cmd_cnt), 32'd1);
    send(8'h81, 8'h00);
    check("R1 disable", 32'(sense_en_o), 32'h0);
    check("R1 func zero", 32'(conv_func_o), 32'h0);

    // R5 write commits only after third byte
    send(8'h40, 8'h00);
    send(8'h12, 8'h00);
    check("R5 not yet committed", 32'(aux_hi_o), 32'h0FFF);
    send(8'h34, 8'h00);
    check("R5 committed", 32'(aux_hi_o), 32'h1234);
    wr(4'h9, 16'h0456); wr(4'hA, 16'hFEDC); wr(4'hB, 16'h0011);
    check("R6 aux lo", 32'(aux_lo_o), 32'h0456);
    check("R6 temp hi", 32'(temp_hi_o), 32'hFEDC);
    check("R6 temp lo", 32'(temp_lo_o), 32'h0011);

    // R3 R4 read with strobe
    c0 = rd_cnt;
    rd(4'h8, 16'h1234);
    check("R3 strobe count", 32'(rd_cnt - c0), 32'd1);
    check("R3 rd addr", 32'(rd_addr_o), 32'h8);
    rd(4'hB, 16'h0011);

    // R10 mask
    wr(4'hD, 16'hFFFF);
    check("R10 cfg1 mask", 32'(cfg1_o), 32'h0F07);
    rd(4'hD, 16'h0F07);

    // R7 R8
    wr(4'hC, 16'hB5A5);
    check("R7 host", 32'(host_mode_o), 32'h1);
    check("R7 enable", 32'(sense_en_o), 32'h1);
    check("R7 prec", 32'(conv_prec_o), 32'h1);
    check("R7 timing", 32'(timing_o), 32'h15A5);
    check("R9 no abort", 32'(abort_cnt), 32'd0);
    pen_down_i = 1'b1; busy_i = 1'b1;
    rd(4'hC, 16'hB5A5);
    pen_down_i = 1'b0; busy_i = 1'b0;
    rd(4'hC, 16'h75A5);

    // R9 abort
    busy_i = 1'b1;
    wr(4'hC, 16'h4000);
    busy_i = 1'b0;
    check("R9 abort pulse", 32'(abort_cnt), 32'd1);
    check("R9 enable cleared", 32'(sense_en_o), 32'h0);
    check("R7 timing cleared", 32'(timing_o), 32'h0);

    // R11
    wr(4'hE, 16'h8123);
    check("R11 pin func", 32'(pin_func_o), 32'h2);
    check("R11 filter", 32'(filter_o), 32'h0123);
    rd(4'hE, 16'h8123);

    // R12 discarded write, external read, pd flag (R3)
    wr(4'h3, 16'hDEAD);
    wr(4'hF, 16'hBEEF);
    check("R12 aux hi kept", 32'(aux_hi_o), 32'h1234);
    check("R12 cfg1 kept", 32'(cfg1_o), 32'h0F07);
    check("R12 filter kept", 32'(filter_o), 32'h0123);
    send(8'h2B, 8'h00);
    check("R3 pd flag", 32'(pd_flag_o), 32'h1);
    send(8'h00, 8'hA5);
    send(8'h00, 8'h3C);
    rd(4'hF, 16'hAF3C);

    // R2 zero byte then command
    c0 = rd_cnt;
    send(8'h00, 8'h00);
    check("R2 no strobe", 32'(rd_cnt - c0), 32'd0);
    send(8'hB0, 8'h00);
    check("R2 next byte is first", 32'(conv_func_o), 32'h6);

    // R13 deselect mid write
    send(8'h40, 8'h00);
    send(8'h99, 8'h00);
    @(negedge clk);
    sel_i = 1'b0; rx_valid_i = 1'b1; rx_byte_i = 8'h55;
    @(negedge clk);
    rx_valid_i = 1'b0; rx_byte_i = 8'h00; sel_i = 1'b1;
    repeat (2) @(negedge clk);
    c0 = cmd_cnt;
    send(8'h88, 8'h00);
    check("R13 command after deselect", 32'(conv_func_o), 32'h1);
    check("R13 cmd strobe", 32'(cmd_cnt - c0), 32'd1);
    check("R13 write discarded", 32'(aux_hi_o), 32'h1234);

    // R1 reset command
    send(8'h82, 8'h00);
    check("R1 soft reset pulse", 32'(srst_cnt), 32'd1);
    check("R1 aux hi restored", 32'(aux_hi_o), 32'h0FFF);
    check("R1 cfg1 cleared", 32'(cfg1_o), 32'h0);
    check("R1 sense off", 32'(sense_en_o), 32'h0);

    // R14 one response per accepted byte
    repeat (3) @(negedge clk);
    check("R14 response count", 32'(txv_cnt), 32'(sent));
    check("R14 queue drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule